// File: doc/BRIEF.md
# Discarded-Read Bank Register Loader

This block sits beside a 65xx-style processor and fills a bank register without the processor ever issuing a write. Software places one of two otherwise-meaningless NOP opcodes in its instruction stream. The processor fetches the bytes these opcodes name and then discards them. The block watches the bus, follows the cycles that come after such an opcode fetch, and copies the discarded byte from the data bus into its register.

Two forms are supported. In the zero-page form, the opcode is followed by an operand byte that gives a zero-page address. The byte the processor reads from that address in the third bus cycle becomes the new bank value, so a load takes three cycles. In the immediate form, the operand byte itself is captured on the second cycle. Bus cycles are qualified by a clock enable. Clocks without it leave the block untouched. Memory-map decoding is done elsewhere.

Top module: `nop_bank_loader`

## Requirements
- R1: While reset is asserted, and directly after it, the bank register reads 0 and the load strobe is low.
- R2: A bus cycle counts only on a clock where busEn is high. An opcode fetch is a counted cycle with opSync high and busRnw high (1 = read). The zero-page trigger opcode defaults to 8'h44 and the immediate trigger opcode defaults to 8'h02.
- R3: Zero-page form. A fetch of the zero-page trigger opcode is followed by a read that returns operand byte P. If the next counted cycle is a read at address 16'h00PP (upper byte zero, low byte P), its data byte becomes the bank value.
- R4: Immediate form. A fetch of the immediate trigger opcode makes the data byte of the next counted read the bank value.
- R5: If the third cycle of the zero-page form reads any address other than 16'h00PP, including one with a nonzero upper byte, the sequence ends without a load.
- R6: A write cycle (busRnw low) anywhere in a tracked sequence ends it without a load, and the bank register keeps its value.
- R7: An opcode fetch in the middle of a tracked sequence ends that sequence without a load. If that fetch is itself a trigger opcode, it starts a new sequence.
- R8: Clocks with busEn low do not advance a sequence, whatever the bus carries on them.
- R9: Each completed load raises loadStrobe for exactly one clock. This is the clock after the capturing bus cycle, and bankReg shows the new value during it. Outside such clocks, bankReg does not change.
- R10: An opcode fetch of any other value starts no sequence and causes no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Marks a clock that carries a valid bus cycle |
| opSync | input | 1 | High during an opcode fetch cycle |
| busRnw | input | 1 | 1 = read, 0 = write |
| busAddr | input | 16 | Address bus |
| busData | input | 8 | Data bus as seen in the cycle |
| bankReg | output | 8 | Current bank value |
| loadStrobe | output | 1 | One-clock pulse after each load |

## Verification
The assertions assume that the processor never raises the sync line on a write, and that the data bus is settled on every clock where busEn is high. The random stimulus honours both conditions by building every cycle as either a read or a plain write, and it asserts opSync only on reads. The random stimulus is weighted toward the two trigger opcodes and toward the correct zero-page target address, so that completed loads, aborted sequences and gaps with busEn low all occur many times.

// File: rtl/nop_bank_loader_pkg.sv
package nop_bank_loader_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ZP_OPER = 2'd1,
    ST_ZP_TGT  = 2'd2,
    ST_IMM_OPR = 2'd3
  } seqState_t;

  typedef struct packed {
    logic captureOperand;
    logic loadBank;
  } ctrlStrobes_t;

endpackage

// File: rtl/nop_bank_loader_ctrl.sv
module nop_bank_loader_ctrl
  import nop_bank_loader_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busEn,
  input  logic         opSync,
  input  logic         busRnw,
  input  logic         isZpOpc,
  input  logic         isImmOpc,
  input  logic         addrHit,
  output ctrlStrobes_t ctrl
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    if (busEn) begin
      if (!busRnw) begin
        stateD = ST_IDLE;
      end else if (opSync) begin
        if (isZpOpc)       stateD = ST_ZP_OPER;
        else if (isImmOpc) stateD = ST_IMM_OPR;
        else               stateD = ST_IDLE;
      end else begin
        unique case (stateQ)
          ST_ZP_OPER: begin
            ctrl.captureOperand = 1'b1;
            stateD = ST_ZP_TGT;
          end
          ST_ZP_TGT: begin
            ctrl.loadBank = addrHit;
            stateD = ST_IDLE;
          end
          ST_IMM_OPR: begin
            ctrl.loadBank = 1'b1;
            stateD = ST_IDLE;
          end
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/nop_bank_loader_dp.sv
module nop_bank_loader_dp
  import nop_bank_loader_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter logic [7:0]  ZP_OPC  = 8'h44,
  parameter logic [7:0]  IMM_OPC = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              isZpOpc,
  output logic              isImmOpc,
  output logic              addrHit,
  output logic [DATA_W-1:0] bankReg,
  output logic              loadStrobe
);

  localparam int unsigned HIGH_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] operandQ;

  assign isZpOpc  = (busData == DATA_W'(ZP_OPC));
  assign isImmOpc = (busData == DATA_W'(IMM_OPC));
  assign addrHit  = (busAddr[ADDR_W-1:DATA_W] == {HIGH_W{1'b0}}) &&
                    (busAddr[DATA_W-1:0] == operandQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operandQ   <= '0;
      bankReg    <= '0;
      loadStrobe <= 1'b0;
    end else begin
      if (ctrl.captureOperand) operandQ <= busData;
      if (ctrl.loadBank)       bankReg  <= busData;
      loadStrobe <= ctrl.loadBank;
    end
  end

endmodule

// File: rtl/nop_bank_loader.sv
module nop_bank_loader
  import nop_bank_loader_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter logic [7:0]  ZP_OPC  = 8'h44,
  parameter logic [7:0]  IMM_OPC = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              opSync,
  input  logic              busRnw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] bankReg,
  output logic              loadStrobe
);

  ctrlStrobes_t ctrl;
  logic isZpOpc, isImmOpc, addrHit;

  nop_bank_loader_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .opSync(opSync), .busRnw(busRnw),
    .isZpOpc(isZpOpc), .isImmOpc(isImmOpc), .addrHit(addrHit), .ctrl(ctrl)
  );

  nop_bank_loader_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZP_OPC(ZP_OPC), .IMM_OPC(IMM_OPC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busAddr(busAddr), .busData(busData),
    .isZpOpc(isZpOpc), .isImmOpc(isImmOpc), .addrHit(addrHit),
    .bankReg(bankReg), .loadStrobe(loadStrobe)
  );

endmodule

// File: rtl/nop_bank_loader_chk.sv
module nop_bank_loader_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busEn,
  input logic              opSync,
  input logic              busRnw,
  input logic [DATA_W-1:0] busData,
  input logic [DATA_W-1:0] bankReg,
  input logic              loadStrobe
);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |-> $stable(bankReg));

  p_write_no_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busRnw) |=> !loadStrobe);

  p_fetch_no_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && opSync) |=> !loadStrobe);

  p_idle_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !loadStrobe);

  p_capture_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> (bankReg == $past(busData)));

endmodule

bind nop_bank_loader nop_bank_loader_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busEn(busEn), .opSync(opSync), .busRnw(busRnw),
  .busData(busData), .bankReg(bankReg), .loadStrobe(loadStrobe)
);

// File: tb/nop_bank_loader_tb_top.sv
`timescale 1ns/1ps
module nop_bank_loader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        opSync = 1'b0;
  logic        busRnw = 1'b1;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic [7:0]  bankReg;
  logic        loadStrobe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state: 0 idle, 1 awaiting operand, 2 awaiting target, 3 awaiting immediate
  int       mPhase = 0;
  logic [7:0] mOper = '0;
  logic [7:0] mBank = '0;
  logic       mStrobe = 1'b0;

  always #10 clk = ~clk;

  nop_bank_loader dut_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .opSync(opSync), .busRnw(busRnw),
    .busAddr(busAddr), .busData(busData), .bankReg(bankReg), .loadStrobe(loadStrobe)
  );

  task automatic check(string tag, logic [7:0] actB, logic [7:0] expB, logic actS, logic expS);
    checks++;
    if (actB !== expB || actS !== expS) begin
      fails++;
      $display("FAIL %s: bank=%02h strobe=%0b expected bank=%02h strobe=%0b",
               tag, actB, actS, expB, expS);
    end
  endtask

  function automatic void modelStep(logic en, logic sy, logic rd, logic [15:0] a, logic [7:0] d);
    mStrobe = 1'b0;
    if (!en) return;
    if (!rd) begin mPhase = 0; return; end
    if (sy) begin
      mPhase = (d == 8'h44) ? 1 : (d == 8'h02) ? 3 : 0;
      return;
    end
    case (mPhase)
      1: begin mOper = d; mPhase = 2; end
      2: begin
        if (a == {8'h00, mOper}) begin mBank = d; mStrobe = 1'b1; end
        mPhase = 0;
      end
      3: begin mBank = d; mStrobe = 1'b1; mPhase = 0; end
      default: mPhase = 0;
    endcase
  endfunction

  task automatic cyc(string tag, logic en, logic sy, logic rd, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busEn = en; opSync = sy; busRnw = rd; busAddr = a; busData = d;
    modelStep(en, sy, rd, a, d);
    @(posedge clk);
    #2;
    check(tag, bankReg, mBank, loadStrobe, mStrobe);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset held", bankReg, 8'h00, loadStrobe, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    cyc("R1 after reset", 1'b0, 1'b0, 1'b1, 16'h0000, 8'hFF);

    // R3 zero-page load
    cyc("R2 zp fetch", 1, 1, 1, 16'h1000, 8'h44);
    cyc("R3 zp operand", 1, 0, 1, 16'h1001, 8'h69);
    cyc("R3 zp target", 1, 0, 1, 16'h0069, 8'hA5);
    if (bankReg !== 8'hA5) begin fails++; $display("FAIL R3: bank=%02h expected a5", bankReg); end
    checks++;
    cyc("R9 strobe drops", 0, 0, 1, 16'h0000, 8'h00);

    // R4 immediate load
    cyc("R2 imm fetch", 1, 1, 1, 16'h1002, 8'h02);
    cyc("R4 imm operand", 1, 0, 1, 16'h1003, 8'h3C);
    if (bankReg !== 8'h3C) begin fails++; $display("FAIL R4: bank=%02h expected 3c", bankReg); end
    checks++;

    // R5 address mismatch, low byte and high byte
    cyc("R5 fetch", 1, 1, 1, 16'h1004, 8'h44);
    cyc("R5 operand", 1, 0, 1, 16'h1005, 8'h20);
    cyc("R5 wrong low", 1, 0, 1, 16'h0021, 8'h11);
    cyc("R5 fetch2", 1, 1, 1, 16'h1006, 8'h44);
    cyc("R5 operand2", 1, 0, 1, 16'h1007, 8'h20);
    cyc("R5 high byte set", 1, 0, 1, 16'h0120, 8'h12);

    // R6 write abort
    cyc("R6 fetch", 1, 1, 1, 16'h1008, 8'h44);
    cyc("R6 operand", 1, 0, 1, 16'h1009, 8'h30);
    cyc("R6 write", 1, 0, 0, 16'h0030, 8'h99);
    cyc("R6 late read", 1, 0, 1, 16'h0030, 8'h98);
    cyc("R6 imm fetch", 1, 1, 1, 16'h100A, 8'h02);
    cyc("R6 imm write", 1, 0, 0, 16'h2000, 8'h97);

    // R7 restart by a new opcode fetch
    cyc("R7 fetch zp", 1, 1, 1, 16'h100B, 8'h44);
    cyc("R7 refetch imm", 1, 1, 1, 16'h100C, 8'h02);
    cyc("R7 new imm load", 1, 0, 1, 16'h100D, 8'h77);
    cyc("R7 fetch imm", 1, 1, 1, 16'h100E, 8'h02);
    cyc("R7 refetch other", 1, 1, 1, 16'h100F, 8'hEA);
    cyc("R7 no load", 1, 0, 1, 16'h1010, 8'h55);

    // R8 gaps do not advance
    cyc("R8 fetch imm", 1, 1, 1, 16'h1011, 8'h02);
    cyc("R8 gap", 0, 0, 1, 16'h0000, 8'hEE);
    cyc("R8 gap sync", 0, 1, 1, 16'h0000, 8'h44);
    cyc("R8 gap write", 0, 0, 0, 16'h0000, 8'hDD);
    cyc("R8 load after gap", 1, 0, 1, 16'h1012, 8'h5A);

    // R10 other opcode
    cyc("R10 other fetch", 1, 1, 1, 16'h1013, 8'hEA);
    cyc("R10 follow read", 1, 0, 1, 16'h1014, 8'hC3);
    cyc("R10 follow read2", 1, 0, 1, 16'h00C3, 8'hC4);

    // random traffic against the model (R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] d;
      logic [15:0] a;
      r = int'($urandom % 12);
      d = 8'($urandom);
      a = 16'($urandom);
      case (r)
        0, 1: cyc("R3 rnd zp fetch", 1, 1, 1, a, 8'h44);
        2, 3: cyc("R4 rnd imm fetch", 1, 1, 1, a, 8'h02);
        4:    cyc("R10 rnd fetch", 1, 1, 1, a, d);
        5:    cyc("R6 rnd write", 1, 0, 0, a, d);
        6:    cyc("R8 rnd gap", 0, 1'($urandom), 1'($urandom), a, d);
        default: begin
          if (mPhase == 2 && ($urandom % 4) != 0) a = {8'h00, mOper};
          else if (mPhase == 2 && ($urandom % 2) != 0) a = {8'h01, mOper};
          cyc("R9 rnd read", 1, 0, 1, a, d);
        end
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule